// File: doc/BRIEF.md
# UART Hardware Flow-Control Gate

This block sits between a UART's transmit and receive FIFOs and the serial modem pins. On the transmit side it gates the start of each new character using the clear-to-send input. On the receive side it drives the request-to-send output from the receive FIFO fill level. Firmware writes the control inputs, and the same output pin can be switched to act as a half-duplex line-driver direction signal.

The clear-to-send pin is active low and asynchronous. It passes through a synchronizer. Any change of the synchronized level can latch an interrupt request, which stays set until it is cleared.

In flow-control mode, request-to-send follows a manual control bit. Once that bit is set and the automatic mode is enabled, the output is released when the receive fill level rises above an upper threshold. It is asserted again when the fill level falls below a lower threshold. Both thresholds are set in steps of STEP entries.

In direction mode, request-to-send is asserted (driven low) for as long as the transmitter has work to do: a character in the shifter or data in the transmit FIFO.

Top module: `rts_cts_flow`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes its reset state from the next edge on. In that state `rts_n` is 1, `cts_irq` is 0, and the synchronized clear-to-send level reads as deasserted. So `tx_allowed` is 0 if `auto_cts_en` is 1.
- R2: `tx_allowed` is 1 whenever `auto_cts_en` is 0. When `auto_cts_en` is 1, `tx_allowed` is the inverse of `cts_n_pin` as seen two clock edges later. Only the start of a new character is gated; a character already in the shifter is not affected.
- R3: With `dir_mode` 0 and `rts_manual` 0, `rts_n` is 1 after the next edge, whatever `auto_rts_en` and `rx_level` are.
- R4: With `dir_mode` 0, `rts_manual` 1 and `auto_rts_en` 0, `rts_n` is 0 after the next edge.
- R5: With `dir_mode` 0, `rts_manual` 1 and `auto_rts_en` 1, the thresholds are upper = `hi_code`*STEP and lower = `lo_code`*STEP (STEP = 4 by default).
    - If `hi_code` > `lo_code` and `rx_level` > upper, `rts_n` becomes 1 after the next edge.
    - If `rx_level` < lower, `rts_n` becomes 0 after the next edge.
    - Otherwise, including equality with either threshold, `rts_n` keeps its value.
    - The hold-off state is cleared whenever `rts_manual` or `auto_rts_en` is 0.
- R6: If `hi_code` <= `lo_code` while automatic RTS is active, the threshold settings are invalid and `rts_n` keeps its present value whatever `rx_level` is.
- R7: With `dir_mode` 1, `rts_n` is 0 after the next edge whenever `tx_fifo_empty` or `tx_shift_idle` is 0. It is 1 after the next edge when both are 1. The manual and automatic controls have no effect in this mode.
- R8: When the synchronized clear-to-send level changes in either direction and `cts_irq_en` is 1, `cts_irq` is 1 from the following edge (three edges after the pin change). It stays 1 until cleared. With `cts_irq_en` 0 a change does not set it.
- R9: `irq_clear` high at an edge clears `cts_irq`, unless a new enabled change is seen at the same edge; in that case the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Receive FIFO fill level |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_shift_idle | input | 1 | Transmit shifter has sent its last stop bit |
| auto_rts_en | input | 1 | Enable automatic RTS from the fill level |
| auto_cts_en | input | 1 | Enable transmit gating by clear-to-send |
| dir_mode | input | 1 | Use RTS as half-duplex direction output |
| rts_manual | input | 1 | Manual RTS request (1 = assert) |
| hi_code | input | $clog2(FIFO_DEPTH/STEP) | Upper threshold in STEP units |
| lo_code | input | $clog2(FIFO_DEPTH/STEP) | Lower threshold in STEP units |
| cts_irq_en | input | 1 | Enable the clear-to-send change interrupt |
| irq_clear | input | 1 | Clear the clear-to-send change interrupt |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_allowed | output | 1 | Transmitter may start a new character |
| cts_irq | output | 1 | Clear-to-send change interrupt request |

## Verification
The properties assume that the control inputs and `rx_level` are stable around the rising edge. They also assume that `rx_level` never exceeds FIFO_DEPTH. The bench changes every input only at the falling edge and draws the fill level from 0 to FIFO_DEPTH. Threshold codes are mostly drawn with the upper above the lower, and a share of invalid pairs is kept to reach the hold case. The clear-to-send pin is toggled at random cycle boundaries, so the synchronizer is exercised only with clean, edge-aligned changes.

// File: rtl/rcf_pkg.sv
// Shared types for the RTS/CTS flow-control block.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rcf_pkg;

    // Source that decides the next RTS pin level.
    typedef enum logic [1:0] {
        RTS_RELEASED  = 2'd0,
        RTS_FORCED    = 2'd1,
        RTS_HYSTERESIS = 2'd2,
        RTS_DIRECTION = 2'd3
    } rts_src_e;

    // Pick the RTS source from the mode controls; direction mode has priority.
    function automatic rts_src_e pick_rts_src(input logic dir_mode,
                                              input logic manual,
                                              input logic auto_en);
        rts_src_e s;
        if (dir_mode)      s = RTS_DIRECTION;
        else if (!manual)  s = RTS_RELEASED;
        else if (auto_en)  s = RTS_HYSTERESIS;
        else               s = RTS_FORCED;
        return s;
    endfunction

endpackage

// File: rtl/rcf_cts_sync.sv
// Synchronizes the active-low clear-to-send pin and raises a sticky
// interrupt request on any change of the synchronized level.
// Assumes: SYNC_STAGES >= 2; the chain resets to "deasserted" (1).
module rcf_cts_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_pin,
    input  logic irq_en,
    input  logic irq_clear,
    output logic cts_ok,
    output logic irq
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   level_edge;

    // First stage captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= cts_n_pin;
    end

    // Remaining stages shift the captured value along.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b1;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // Remember the last synchronized level to find changes.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign level_edge = chain_q[SYNC_STAGES-1] ^ prev_q;

    // Sticky request: a new enabled change wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq <= 1'b0;
        else if (level_edge && irq_en) irq <= 1'b1;
        else if (irq_clear)            irq <= 1'b0;
    end

    assign cts_ok = ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/rcf_rts_hyst.sv
// Hysteresis tracker for automatic RTS: sets a hold-off flag when the
// receive fill level exceeds the upper threshold and clears it below the
// lower one. An invalid pair (upper <= lower) freezes the flag.
// Assumes: rx_level <= FIFO_DEPTH; FIFO_DEPTH is a multiple of STEP.
module rcf_rts_hyst #(
    parameter int FIFO_DEPTH = 32,
    parameter int STEP       = 4,
    localparam int FILL_W    = $clog2(FIFO_DEPTH + 1),
    localparam int CODE_W    = $clog2(FIFO_DEPTH / STEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [FILL_W-1:0] rx_level,
    input  logic [CODE_W-1:0] hi_code,
    input  logic [CODE_W-1:0] lo_code,
    output logic              hold_next
);

    logic [FILL_W-1:0] upper_lvl;
    logic [FILL_W-1:0] lower_lvl;
    logic              pair_ok;
    logic              hold_q;

    // Scale the threshold codes into fill-level units.
    always_comb begin
        upper_lvl = FILL_W'(hi_code) * FILL_W'(STEP);
        lower_lvl = FILL_W'(lo_code) * FILL_W'(STEP);
        pair_ok   = hi_code > lo_code;
    end

    // Next hold-off value from the fill level and the thresholds.
    always_comb begin
        if (!active)                             hold_next = 1'b0;
        else if (pair_ok && rx_level > upper_lvl) hold_next = 1'b1;
        else if (pair_ok && rx_level < lower_lvl) hold_next = 1'b0;
        else                                      hold_next = hold_q;
    end

    // Hold-off state register.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_next;
    end

endmodule

// File: rtl/rcf_rts_drive.sv
// Selects the RTS source and registers the pin level.
// Assumes: hold_next is this cycle's hysteresis decision.
module rcf_rts_drive
    import rcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir_mode,
    input  logic manual,
    input  logic auto_en,
    input  logic tx_busy,
    input  logic hold_next,
    output logic rts_n
);

    rts_src_e src;
    logic     rts_n_d;

    // Decode the pin level for the selected source.
    always_comb begin
        src = pick_rts_src(dir_mode, manual, auto_en);
        unique case (src)
            RTS_DIRECTION:  rts_n_d = ~tx_busy;
            RTS_RELEASED:   rts_n_d = 1'b1;
            RTS_HYSTERESIS: rts_n_d = hold_next;
            default:        rts_n_d = 1'b0;
        endcase
    end

    // Output register; pin idles deasserted.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n <= 1'b1;
        else        rts_n <= rts_n_d;
    end

endmodule

// File: rtl/rts_cts_flow.sv
// Top of the RTS/CTS flow-control gate: CTS synchronizer with change
// interrupt, automatic RTS hysteresis and half-duplex direction drive.
// Assumes: inputs other than cts_n_pin are synchronous to clk.
module rts_cts_flow #(
    parameter int FIFO_DEPTH  = 32,
    parameter int STEP        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int FILL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int CODE_W     = $clog2(FIFO_DEPTH / STEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_n_pin,
    input  logic [FILL_W-1:0] rx_level,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_idle,
    input  logic              auto_rts_en,
    input  logic              auto_cts_en,
    input  logic              dir_mode,
    input  logic              rts_manual,
    input  logic [CODE_W-1:0] hi_code,
    input  logic [CODE_W-1:0] lo_code,
    input  logic              cts_irq_en,
    input  logic              irq_clear,
    output logic              rts_n,
    output logic              tx_allowed,
    output logic              cts_irq
);

    logic cts_ok;
    logic hold_next;
    logic tx_busy;
    logic hyst_active;

    // Transmitter busy and hysteresis-active conditions.
    always_comb begin
        tx_busy     = ~(tx_fifo_empty & tx_shift_idle);
        hyst_active = rts_manual & auto_rts_en;
    end

    rcf_cts_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cts_n_pin(cts_n_pin),
        .irq_en(cts_irq_en), .irq_clear(irq_clear),
        .cts_ok(cts_ok), .irq(cts_irq)
    );

    rcf_rts_hyst #(.FIFO_DEPTH(FIFO_DEPTH), .STEP(STEP)) u_hyst (
        .clk(clk), .rst_n(rst_n), .active(hyst_active),
        .rx_level(rx_level), .hi_code(hi_code), .lo_code(lo_code),
        .hold_next(hold_next)
    );

    rcf_rts_drive u_drive (
        .clk(clk), .rst_n(rst_n), .dir_mode(dir_mode),
        .manual(rts_manual), .auto_en(auto_rts_en),
        .tx_busy(tx_busy), .hold_next(hold_next), .rts_n(rts_n)
    );

    // Gate new characters only when CTS gating is enabled.
    assign tx_allowed = ~auto_cts_en | cts_ok;

endmodule

// File: rtl/rcf_checker.sv
// Property checker for rts_cts_flow, attached with bind.
module rcf_checker #(
    parameter int FIFO_DEPTH = 32,
    parameter int STEP       = 4,
    localparam int FILL_W    = $clog2(FIFO_DEPTH + 1),
    localparam int CODE_W    = $clog2(FIFO_DEPTH / STEP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FILL_W-1:0] rx_level,
    input logic              tx_fifo_empty,
    input logic              tx_shift_idle,
    input logic              auto_rts_en,
    input logic              auto_cts_en,
    input logic              dir_mode,
    input logic              rts_manual,
    input logic [CODE_W-1:0] hi_code,
    input logic [CODE_W-1:0] lo_code,
    input logic              cts_irq_en,
    input logic              irq_clear,
    input logic              rts_n,
    input logic              tx_allowed,
    input logic              cts_irq
);

    logic [FILL_W-1:0] up_c;
    logic [FILL_W-1:0] lo_c;
    assign up_c = FILL_W'(hi_code) * FILL_W'(STEP);
    assign lo_c = FILL_W'(lo_code) * FILL_W'(STEP);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (rts_n && !cts_irq));

    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |-> tx_allowed);

    assert_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_mode && !rts_manual) |=> rts_n);

    assert_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_mode && rts_manual && !auto_rts_en) |=> !rts_n);

    assert_hyst_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_mode && rts_manual && auto_rts_en && hi_code > lo_code && rx_level > up_c) |=> rts_n);

    assert_hyst_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_mode && rts_manual && auto_rts_en && hi_code > lo_code && rx_level < lo_c) |=> !rts_n);

    assert_invalid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_mode && rts_manual && auto_rts_en && hi_code <= lo_code
         && $past(rst_n) && $past(!dir_mode && rts_manual && auto_rts_en)) |=> $stable(rts_n));

    assert_dir_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode && !(tx_fifo_empty && tx_shift_idle)) |=> !rts_n);

    assert_dir_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode && tx_fifo_empty && tx_shift_idle) |=> rts_n);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_irq && !irq_clear) |=> cts_irq);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !cts_irq_en) |=> !cts_irq);

endmodule

bind rts_cts_flow rcf_checker #(.FIFO_DEPTH(FIFO_DEPTH), .STEP(STEP)) u_rcf_checker (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
    .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .dir_mode(dir_mode), .rts_manual(rts_manual),
    .hi_code(hi_code), .lo_code(lo_code),
    .cts_irq_en(cts_irq_en), .irq_clear(irq_clear),
    .rts_n(rts_n), .tx_allowed(tx_allowed), .cts_irq(cts_irq)
);

// File: tb/rts_cts_flow_bench.sv
module rts_cts_flow_bench;

    localparam int DEPTH  = 32;
    localparam int STP    = 4;
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int CODE_W = $clog2(DEPTH / STP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n_pin = 1'b1;
    logic [FILL_W-1:0] rx_level = '0;
    logic tx_fifo_empty = 1'b1, tx_shift_idle = 1'b1;
    logic auto_rts_en = 1'b0, auto_cts_en = 1'b1, dir_mode = 1'b0, rts_manual = 1'b0;
    logic [CODE_W-1:0] hi_code = CODE_W'(6), lo_code = CODE_W'(2);
    logic cts_irq_en = 1'b0, irq_clear = 1'b0;
    logic rts_n, tx_allowed, cts_irq;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state, updated from the requirements each rising edge.
    logic m1 = 1'b1, m2 = 1'b1, m3 = 1'b1, mhold = 1'b0, mrts = 1'b1, mirq = 1'b0;

    always #5 clk = ~clk;

    rts_cts_flow u_rts_cts_flow (
        .clk(clk), .rst_n(rst_n), .cts_n_pin(cts_n_pin), .rx_level(rx_level),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .dir_mode(dir_mode),
        .rts_manual(rts_manual), .hi_code(hi_code), .lo_code(lo_code),
        .cts_irq_en(cts_irq_en), .irq_clear(irq_clear),
        .rts_n(rts_n), .tx_allowed(tx_allowed), .cts_irq(cts_irq)
    );

    function automatic logic exp_hold(input logic h);
        int up, lo;
        up = int'(hi_code) * STP;
        lo = int'(lo_code) * STP;
        if (!(rts_manual && auto_rts_en)) return 1'b0;
        if (hi_code > lo_code && int'(rx_level) > up) return 1'b1;
        if (hi_code > lo_code && int'(rx_level) < lo) return 1'b0;
        return h;
    endfunction

    function automatic string rts_tag();
        if (dir_mode) return "R7";
        if (!rts_manual) return "R3";
        if (!auto_rts_en) return "R4";
        if (hi_code > lo_code) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: advance the reference at the edge, compare at the falling edge.
    task automatic tick();
        string rt, it;
        logic hn, edge_seen;
        @(posedge clk);
        rt = rts_tag();
        it = irq_clear ? "R9" : "R8";
        if (!rst_n) begin
            m1 = 1; m2 = 1; m3 = 1; mhold = 0; mrts = 1; mirq = 0;
        end else begin
            hn = exp_hold(mhold);
            edge_seen = m2 ^ m3;
            if (edge_seen && cts_irq_en) mirq = 1;
            else if (irq_clear) mirq = 0;
            if (dir_mode) mrts = tx_fifo_empty && tx_shift_idle;
            else if (!rts_manual) mrts = 1;
            else if (auto_rts_en) mrts = hn;
            else mrts = 0;
            mhold = hn;
            m3 = m2; m2 = m1; m1 = cts_n_pin;
        end
        @(negedge clk);
        if (rst_n) begin
            check(rt, "rts_n", rts_n, mrts);
            check("R2", "tx_allowed", tx_allowed, !auto_cts_en || !m2);
            check(it, "cts_irq", cts_irq, mirq);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1", "reset rts_n", rts_n, 1'b1);
        check("R1", "reset cts_irq", cts_irq, 1'b0);
        check("R1", "reset tx_allowed", tx_allowed, 1'b0);

        // R3: manual off keeps RTS released even with a low fill and auto on.
        auto_rts_en = 1; rx_level = '0; tick(); tick();
        check("R3", "released", rts_n, 1'b1);
        // R4: manual on, auto off.
        auto_rts_en = 0; rts_manual = 1; rx_level = FILL_W'(32); tick();
        check("R4", "forced", rts_n, 1'b0);
        // R5: sweep the fill level up and down across the thresholds (24 / 8).
        auto_rts_en = 1;
        for (int f = 0; f <= DEPTH; f++) begin rx_level = FILL_W'(f); tick(); end
        check("R5", "above upper", rts_n, 1'b1);
        rx_level = FILL_W'(8); tick();
        check("R5", "at lower holds", rts_n, 1'b1);
        rx_level = FILL_W'(7); tick();
        check("R5", "below lower", rts_n, 1'b0);
        rx_level = FILL_W'(24); tick();
        check("R5", "at upper holds", rts_n, 1'b0);
        // R6: equal codes freeze the state.
        hi_code = CODE_W'(3); lo_code = CODE_W'(3); rx_level = FILL_W'(32); tick(); tick();
        check("R6", "invalid pair holds", rts_n, 1'b0);
        hi_code = CODE_W'(6); lo_code = CODE_W'(2);
        // R7: direction mode overrides manual/auto.
        dir_mode = 1; tx_fifo_empty = 0; tick();
        check("R7", "busy drives", rts_n, 1'b0);
        tx_fifo_empty = 1; tx_shift_idle = 0; tick();
        check("R7", "last stop bit pending", rts_n, 1'b0);
        tx_shift_idle = 1; tick();
        check("R7", "idle releases", rts_n, 1'b1);
        dir_mode = 0;
        // R2 / R8 / R9: CTS change with interrupts.
        cts_irq_en = 1; cts_n_pin = 0; tick(); tick();
        check("R2", "cts asserted", tx_allowed, 1'b1);
        tick();
        check("R8", "irq raised", cts_irq, 1'b1);
        irq_clear = 1; tick(); irq_clear = 0;
        check("R9", "irq cleared", cts_irq, 1'b0);
        cts_irq_en = 0; cts_n_pin = 1; repeat (4) tick();
        check("R8", "disabled no irq", cts_irq, 1'b0);
        check("R2", "cts released", tx_allowed, 1'b0);

        // Random phase, compared every cycle against the reference.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) cts_n_pin = ~cts_n_pin;
            rx_level = FILL_W'($urandom_range(0, DEPTH));
            tx_fifo_empty = ($urandom_range(0, 3) != 0);
            tx_shift_idle = ($urandom_range(0, 3) != 0);
            irq_clear = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 31) == 0) begin
                auto_rts_en = ($urandom_range(0, 3) != 0);
                auto_cts_en = $urandom_range(0, 1) == 1;
                dir_mode = ($urandom_range(0, 4) == 0);
                rts_manual = ($urandom_range(0, 4) != 0);
                cts_irq_en = $urandom_range(0, 1) == 1;
                lo_code = CODE_W'($urandom_range(0, 6));
                hi_code = ($urandom_range(0, 5) == 0) ? CODE_W'($urandom_range(0, 7))
                        : CODE_W'($urandom_range(int'(lo_code) + 1, 7));
            end
            tick();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule